// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address sequence for a bus master that performs single, incrementing and wrapping bursts on a pipelined, AHB-style bus. A burst starts with a one-cycle `start` pulse. With that pulse the block captures the start address, the burst kind, the wrap window size, the transfer size and the length of an incrementing burst. From then on it produces each following address itself, so the master never has to send a second address phase.

A wrapping burst begins at the critical word that the CPU requested. It then walks upward and folds back to the bottom of the aligned window, which is the size of a cache line. For example, a request for the third of four words in a 16-byte line gives the offsets 8, C, 0, 4.

Each beat carries a transfer-type code and a last-beat flag. The sequence advances only on cycles where `ready` is high. While the slave inserts wait states, the address, the control outputs and the captured write data stay frozen.

Top module: `burst_addr_gen`

## Requirements
- R1: After a `start` pulse is accepted while idle, the next cycle presents beat 0 at `start_addr` with `trans` = NONSEQ (2'b10). Every later beat of the same burst shows SEQ (2'b11).
- R2: An incrementing burst (`kind` = 2'b01) lasts `len` beats, where a `len` of 0 counts as 1. Beat i has the address `start_addr` + i·2^`size`.
- R3: A wrapping burst (`kind` = 2'b10) uses a window of W bytes. W is 4, 8 or 16 for `wsel` = 0, 1 or 2, and 16 for `wsel` = 3. Beat i is at base + ((`start_addr` − base + i·2^`size`) mod W), where base is `start_addr` with its low log2(W) bits cleared. The burst has W/2^`size` beats, with a minimum of 1.
- R4: A single transfer (`kind` = 2'b00, and also 2'b11) is one NONSEQ beat at `start_addr`.
- R5: While `ready` is low during a burst, `addr`, `trans`, `last` and `wdata_out` do not change.
- R6: `last` is high exactly on the final beat of a burst. After the final beat is accepted with `ready` high, `trans` returns to IDLE (2'b00) and `last` drops.
- R7: `wdata_out` holds the value of `wdata_in` that was sampled when the current beat was entered, that is, at the accepted start or at the accepted previous beat.
- R8: A `start` pulse that arrives while a burst is in progress is ignored. The ongoing sequence continues unchanged.
- R9: A synchronous active-high `rst` gives `trans` = IDLE, `last` = 0, `addr` = 0 and `wdata_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst, accepted only while idle |
| start_addr | input | AW | First address of the burst |
| kind | input | 2 | 00 single, 01 incrementing, 10 wrapping, 11 single |
| wsel | input | 2 | Wrap window: 0 = 4 B, 1 = 8 B, 2/3 = 16 B |
| size | input | 3 | log2 of the bytes per beat |
| len | input | LENW | Beat count of an incrementing burst (0 counts as 1) |
| ready | input | 1 | Slave ready; the burst advances only when high |
| wdata_in | input | DW | Write data for the beat being entered |
| addr | output | AW | Current beat address |
| trans | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ, 11 SEQ |
| last | output | 1 | High on the final beat |
| wdata_out | output | DW | Write data held for the current beat |

## Verification
The embedded assertions check the cycle-level rules on every cycle:
- outputs stay frozen during stalls;
- NONSEQ follows an accepted start, and SEQ follows each accepted non-final beat;
- the bus returns to IDLE after the final beat;
- the addresses of a wrapping burst never leave their aligned window;
- the beat counter never passes the burst length.

The exact address orders are shown only by the bench's scenarios. These are the critical-word-first order for every start offset, window and size, the incrementing sequences, the beat count with its last-beat position, the write data captured per beat, and the fact that a start pulse during a busy burst is ignored.

// File: rtl/burst_addr_gen_pkg.sv
package burst_addr_gen_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    BK_SINGLE = 2'b00,
    BK_INCR   = 2'b01,
    BK_WRAP   = 2'b10,
    BK_RSVD   = 2'b11
  } burst_kind_e;
endpackage

// File: rtl/bag_cfg_decode.sv
// Turns the request fields into a byte step, a wrap mask and a beat count.
module bag_cfg_decode #(
  parameter int AW   = 32,
  parameter int LENW = 5,
  parameter int CW   = LENW + 1
) (
  input  logic [1:0]    kind,
  input  logic [1:0]    wsel,
  input  logic [2:0]    size,
  input  logic [LENW-1:0] len,
  output logic [AW-1:0] step,
  output logic [AW-1:0] mask,
  output logic          is_wrap,
  output logic [CW-1:0] beats
);
  import burst_addr_gen_pkg::*;

  logic [AW-1:0] window;
  logic [AW-1:0] wrap_beats;

  always_comb begin
    step = AW'(1) << size;
    unique case (wsel)
      2'd0:    window = AW'(4);
      2'd1:    window = AW'(8);
      default: window = AW'(16);
    endcase
    wrap_beats = window >> size;
    is_wrap    = (burst_kind_e'(kind) == BK_WRAP);
    if (is_wrap) begin
      mask = window - AW'(1);
    end else begin
      mask = '0;
    end
    unique case (burst_kind_e'(kind))
      BK_INCR: beats = (len == '0) ? CW'(1) : CW'(len);
      BK_WRAP: beats = (wrap_beats == '0) ? CW'(1) : CW'(wrap_beats);
      default: beats = CW'(1);
    endcase
  end

  always_comb begin
    assert (beats != '0) else $error("beat count zero");
    assert ((step & (step - AW'(1))) == '0) else $error("step not a power of two");
  end
endmodule

// File: rtl/bag_next_addr.sv
// Next address within a burst: a plain increment, or a fold inside the window.
module bag_next_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] mask,
  input  logic          is_wrap,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] sum;

  always_comb begin
    sum = cur + step;
    if (is_wrap) begin
      nxt = (cur & ~mask) | (sum & mask);
    end else begin
      nxt = sum;
    end
  end

  always_comb begin
    if (is_wrap) begin
      assert ((nxt & ~mask) == (cur & ~mask)) else $error("wrap left window");
    end
  end
endmodule

// File: rtl/bag_beat_ctrl.sv
// Beat counter, transfer type and last flag.
module bag_beat_ctrl #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ready,
  input  logic [CW-1:0] beats_in,
  output logic          accept,
  output logic          advance,
  output logic [1:0]    trans,
  output logic          last
);
  import burst_addr_gen_pkg::*;

  trans_e        trans_q;
  logic          last_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] total_q;
  logic          busy;

  assign busy    = (trans_q != TR_IDLE);
  assign accept  = start && !busy;
  assign advance = busy && ready && !last_q;
  assign trans   = trans_q;
  assign last    = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trans_q <= TR_IDLE;
      last_q  <= 1'b0;
      count_q <= '0;
      total_q <= '0;
    end else if (accept) begin
      trans_q <= TR_NONSEQ;
      count_q <= CW'(1);
      total_q <= beats_in;
      last_q  <= (beats_in == CW'(1));
    end else if (busy && ready) begin
      if (last_q) begin
        trans_q <= TR_IDLE;
        last_q  <= 1'b0;
      end else begin
        trans_q <= TR_SEQ;
        count_q <= count_q + CW'(1);
        last_q  <= ((count_q + CW'(1)) == total_q);
      end
    end
  end

  p_nonseq_first_r1: assert property (@(posedge clk) disable iff (rst)
    (start && trans_q == TR_IDLE) |=> (trans_q == TR_NONSEQ));
  p_seq_follows_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && ready && !last_q) |=> (trans_q == TR_SEQ));
  p_idle_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && ready && last_q) |=> (trans_q == TR_IDLE && !last_q));
  p_last_busy_r6: assert property (@(posedge clk) disable iff (rst)
    last_q |-> busy);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (count_q <= total_q && count_q != '0));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !ready) |=> $stable(count_q) && $stable(total_q));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [1:0]      kind,
  input  logic [1:0]      wsel,
  input  logic [2:0]      size,
  input  logic [LENW-1:0] len,
  input  logic            ready,
  input  logic [DW-1:0]   wdata_in,
  output logic [AW-1:0]   addr,
  output logic [1:0]      trans,
  output logic            last,
  output logic [DW-1:0]   wdata_out
);
  import burst_addr_gen_pkg::*;
  localparam int CW = LENW + 1;

  logic [AW-1:0] step_d, mask_d, step_q, mask_q, base_q, addr_q, addr_nx;
  logic          wrap_d, wrap_q;
  logic [CW-1:0] beats_d;
  logic          accept, advance;
  logic [DW-1:0] wdata_q;

  bag_cfg_decode #(.AW(AW), .LENW(LENW), .CW(CW)) u_cfg (
    .kind(kind), .wsel(wsel), .size(size), .len(len),
    .step(step_d), .mask(mask_d), .is_wrap(wrap_d), .beats(beats_d)
  );

  bag_next_addr #(.AW(AW)) u_next (
    .cur(addr_q), .step(step_q), .mask(mask_q), .is_wrap(wrap_q), .nxt(addr_nx)
  );

  bag_beat_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ready(ready), .beats_in(beats_d),
    .accept(accept), .advance(advance), .trans(trans), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      base_q  <= '0;
      step_q  <= '0;
      mask_q  <= '0;
      wrap_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= start_addr;
      base_q  <= start_addr;
      step_q  <= step_d;
      mask_q  <= mask_d;
      wrap_q  <= wrap_d;
      wdata_q <= wdata_in;
    end else if (advance) begin
      addr_q  <= addr_nx;
      wdata_q <= wdata_in;
    end
  end

  assign addr      = addr_q;
  assign wdata_out = wdata_q;

  p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (trans != TR_IDLE && !ready) |=>
      ($stable(addr) && $stable(trans) && $stable(last) && $stable(wdata_out)));
  p_wrap_window_r3: assert property (@(posedge clk) disable iff (rst)
    (trans == TR_SEQ && wrap_q) |-> ((addr_q & ~mask_q) == (base_q & ~mask_q)));
  p_incr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (trans != TR_IDLE && ready && !last && !wrap_q) |=> (addr_q == $past(addr_q) + step_q));
endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LENW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] kind = '0, wsel = '0;
  logic [2:0] size = '0;
  logic [LENW-1:0] len = '0;
  logic ready = 1'b1;
  logic [DW-1:0] wdata_in = '0;
  logic [AW-1:0] addr;
  logic [1:0] trans;
  logic last;
  logic [DW-1:0] wdata_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW), .DW(DW), .LENW(LENW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .kind(kind),
    .wsel(wsel), .size(size), .len(len), .ready(ready), .wdata_in(wdata_in),
    .addr(addr), .trans(trans), .last(last), .wdata_out(wdata_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int win_bytes(input logic [1:0] ws);
    return (ws == 2'd0) ? 4 : (ws == 2'd1) ? 8 : 16;
  endfunction

  function automatic int n_beats(input logic [1:0] k, input logic [1:0] ws, input logic [2:0] sz, input logic [4:0] ln);
    int w = win_bytes(ws);
    if (k == 2'b01) return (ln == 0) ? 1 : int'(ln);
    if (k == 2'b10) return ((w >> sz) == 0) ? 1 : (w >> sz);
    return 1;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [1:0] k, input logic [1:0] ws, input logic [2:0] sz,
                                           input logic [31:0] a, input int i);
    int w = win_bytes(ws);
    logic [31:0] st = 32'(1) << sz;
    logic [31:0] base;
    if (k == 2'b01) return a + st * 32'(i);
    if (k == 2'b10) begin
      base = a & ~32'(w - 1);
      return base + ((a - base + st * 32'(i)) % 32'(w));
    end
    return a;
  endfunction

  task automatic run_burst(input logic [1:0] k, input logic [1:0] ws, input logic [2:0] sz,
                           input logic [31:0] a, input logic [4:0] ln, input bit stall,
                           input bit poke, input string req);
    int n = n_beats(k, ws, sz, ln);
    int i = 0;
    int guard = 0;
    logic [31:0] expwd;
    bit rdy;
    @(negedge clk);
    start = 1; kind = k; wsel = ws; size = sz; start_addr = a; len = ln;
    wdata_in = $urandom; expwd = wdata_in; ready = 1;
    @(posedge clk); #1 start = 0;
    while (i < n && guard < 2000) begin
      guard++;
      @(negedge clk);
      chk(addr == exp_addr(k, ws, sz, a, i), req, addr, exp_addr(k, ws, sz, a, i));
      chk(trans == ((i == 0) ? 2'b10 : 2'b11), "R1", trans, (i == 0) ? 2'b10 : 2'b11);
      chk(last == (i == n - 1), "R6", last, (i == n - 1));
      chk(wdata_out == expwd, "R7", wdata_out, expwd);
      if (poke && i == 0) begin
        start = 1; start_addr = ~a; kind = 2'b01; len = 5'd3;  // R8 busy start
      end
      rdy = stall ? (($urandom % 3) != 0) : 1'b1;
      ready = rdy;
      wdata_in = $urandom;
      if (rdy && i < n - 1) expwd = wdata_in;
      @(posedge clk); #1 start = 0;
      if (rdy) i++;
    end
    @(negedge clk);
    chk(trans == 2'b00, "R6", trans, 2'b00);
    chk(last == 1'b0, "R6", last, 0);
    ready = 1;
  endtask

  // {kind[2], wsel[2], size[3], addr_lo[8], len[5], stall[1]}
  localparam logic [20:0] VEC [12] = '{
    {2'b10, 2'd2, 3'd2, 8'h08, 5'd0, 1'b0},  // R3 words 3,4,1,2
    {2'b10, 2'd2, 3'd2, 8'h2C, 5'd0, 1'b1},  // R3
    {2'b10, 2'd1, 3'd0, 8'h35, 5'd0, 1'b0},  // R3 byte wrap in 8 B
    {2'b10, 2'd0, 3'd1, 8'h12, 5'd0, 1'b1},  // R3
    {2'b10, 2'd0, 3'd3, 8'h40, 5'd0, 1'b0},  // R3 step > window: one beat
    {2'b10, 2'd3, 3'd1, 8'h0E, 5'd0, 1'b1},  // R3 reserved wsel -> 16 B
    {2'b01, 2'd0, 3'd2, 8'hF8, 5'd4, 1'b0},  // R2 crosses 0x100
    {2'b01, 2'd2, 3'd0, 8'h03, 5'd7, 1'b1},  // R2
    {2'b01, 2'd1, 3'd1, 8'h20, 5'd0, 1'b0},  // R2 len 0 -> 1
    {2'b01, 2'd0, 3'd3, 8'h00, 5'd16, 1'b1}, // R2
    {2'b00, 2'd2, 3'd2, 8'h44, 5'd9, 1'b0},  // R4
    {2'b11, 2'd1, 3'd0, 8'h77, 5'd9, 1'b1}   // R4 reserved kind
  };

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(trans == 2'b00, "R9", trans, 0);
    chk(last == 1'b0, "R9", last, 0);
    chk(addr == '0, "R9", addr, 0);
    chk(wdata_out == '0, "R9", wdata_out, 0);

    foreach (VEC[v]) begin
      logic [20:0] e = VEC[v];
      run_burst(e[20:19], e[18:17], e[16:14], {24'h0000A5, e[13:6]}, e[5:1], e[0],
                1'b0, (e[20:19] == 2'b10) ? "R3" : (e[20:19] == 2'b01) ? "R2" : "R4");
    end

    // R3: every start offset, every window, sizes 0..2, random stalls (R5)
    for (int ws = 0; ws < 3; ws++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int off = 0; off < win_bytes(2'(ws)); off += (1 << sz)) begin
          run_burst(2'b10, 2'(ws), 3'(sz), 32'h0000_1230 + 32'(off), 5'd0, 1'b1, 1'b0, "R3");
        end
      end
    end

    // R8: start during a busy burst is ignored
    run_burst(2'b10, 2'd2, 3'd2, 32'h0000_0204, 5'd0, 1'b0, 1'b1, "R8");
    run_burst(2'b01, 2'd0, 3'd2, 32'h0000_0300, 5'd6, 1'b1, 1'b1, "R8");

    // R5: long stall on beat 0, outputs frozen
    @(negedge clk);
    start = 1; kind = 2'b01; wsel = 0; size = 3'd2; start_addr = 32'h500; len = 5'd2;
    wdata_in = 32'hCAFE_0001; ready = 0;
    @(posedge clk); #1 start = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      wdata_in = 32'h1111_0000 + 32'(c);
      chk(addr == 32'h500, "R5", addr, 32'h500);
      chk(trans == 2'b10, "R5", trans, 2'b10);
      chk(wdata_out == 32'hCAFE_0001, "R5", wdata_out, 32'hCAFE_0001);
    end
    ready = 1;
    @(negedge clk);
    chk(addr == 32'h504 && trans == 2'b11 && last, "R5", addr, 32'h504);
    @(negedge clk);
    chk(trans == 2'b00, "R6", trans, 0);

    // R9: reset in mid-burst
    @(negedge clk);
    start = 1; kind = 2'b01; start_addr = 32'h700; len = 5'd8;
    @(negedge clk); start = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(trans == 2'b00 && !last && addr == '0, "R9", {trans, addr}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule